// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer arithmetic logic unit. Two operands of a parameterized width (32 bits by default) enter together with a 4-bit operation code. The block returns a result word, a zero flag, a signed-overflow flag and the carry out of the top adder bit. No clock or reset is involved, so the outputs follow the inputs after the propagation delay of the ripple chain.

The datapath is a row of identical bit slices. Each slice can invert either operand, and it holds an AND gate, an OR gate and a full-adder sum. A 4-way output mux in the slice picks one of these or a "less" input. The carries ripple from bit 0 to the top bit. The operation code breaks into fields that drive the slices directly:

- bit 3 inverts operand A.
- bit 2 inverts operand B and also supplies the carry into bit 0.
- bits 1:0 are the slice-mux select: 00 AND, 01 OR, 10 sum, 11 less.

NOR therefore comes from ANDing both inverted operands. Set-on-less-than routes the sign bit of the subtraction back into the less input of bit 0.

Top module: `ripple_alu`

## Requirements
- R1: Code 0000 gives result = A & B.
- R2: Code 0001 gives result = A | B.
- R3: Code 0010 gives result = (A + B) modulo 2^W, and carry_out equals bit W of the full sum A + B.
- R4: Code 0110 gives result = (A - B) modulo 2^W, computed as A + ~B + 1; carry_out equals bit W of A + ~B + 1, which is 1 exactly when A >= B taken as unsigned numbers.
- R5: Code 0111 gives a result whose bits W-1..1 are 0. Its bit 0 equals the most significant bit of (A - B) modulo 2^W. carry_out is the same as for code 0110.
- R6: Code 1100 gives result = ~(A | B), which equals ~A & ~B.
- R7: zero is 1 exactly when every bit of the result is 0, for every code.
- R8: For codes 0010 and 0110, overflow is 1 exactly when the operation overflows in two's complement. For 0010 that means A and B have the same sign and the result sign differs from it. For 0110 it means A and B differ in sign and the result sign differs from the sign of A.
- R9: For every code other than 0010 and 0110, overflow is 0.
- R10: Every code outside {0000, 0001, 0010, 0110, 0111, 1100} gives result 0, carry_out 0 and zero 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W (32) | First operand |
| opnd_b | input | W (32) | Second operand |
| op_code | input | 4 | Operation code |
| result | output | W (32) | Selected result word |
| zero | output | 1 | High when every result bit is 0 |
| overflow | output | 1 | Two's-complement overflow of add or subtract |
| carry_out | output | 1 | Carry out of the top adder bit |

## Verification
The hardest case to reach from the ports is set-on-less-than when the subtraction overflows. There the raw sign bit of A - B disagrees with the true signed order. A sign mistake on that path can only be seen when the operands sit near opposite ends of the signed range. The bench builds a 4-bit copy of the block and sweeps every operand pair under all sixteen codes, so every overflow and sign-flip combination occurs. The 32-bit instance then gets the extreme values (most negative, most positive, all ones, zero) paired in every combination, followed by a walk of pseudo-random operands.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [1:0] {
        PICK_AND  = 2'b00,
        PICK_OR   = 2'b01,
        PICK_SUM  = 2'b10,
        PICK_LESS = 2'b11
    } slice_pick_e;

    typedef struct packed {
        logic        neg_a;
        logic        neg_b;
        slice_pick_e pick;
        logic        legal;
        logic        arith;
    } slice_ctl_t;

endpackage

// File: rtl/alu_ctl_decode.sv
`timescale 1ns/1ps
module alu_ctl_decode
    import alu_pkg::*;
(
    input  logic [3:0] op_code,
    output slice_ctl_t ctl
);

    always_comb begin
        ctl.neg_a = op_code[3];
        ctl.neg_b = op_code[2];
        ctl.pick  = slice_pick_e'(op_code[1:0]);
        ctl.legal = 1'b0;
        ctl.arith = 1'b0;
        unique case (op_code)
            OP_AND, OP_OR, OP_SLT, OP_NOR: ctl.legal = 1'b1;
            OP_ADD, OP_SUB: begin
                ctl.legal = 1'b1;
                ctl.arith = 1'b1;
            end
            default: ctl.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_bit_slice.sv
`timescale 1ns/1ps
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic        a_bit,
    input  logic        b_bit,
    input  logic        neg_a,
    input  logic        neg_b,
    input  slice_pick_e pick,
    input  logic        carry_in,
    input  logic        less_in,
    output logic        a_eff,
    output logic        b_eff,
    output logic        res_bit
);

    logic and_v;
    logic or_v;
    logic sum_v;

    assign a_eff = neg_a ? ~a_bit : a_bit;
    assign b_eff = neg_b ? ~b_bit : b_bit;
    assign and_v = a_eff & b_eff;
    assign or_v  = a_eff | b_eff;
    assign sum_v = a_eff ^ b_eff ^ carry_in;

    always_comb begin
        unique case (pick)
            PICK_AND:  res_bit = and_v;
            PICK_OR:   res_bit = or_v;
            PICK_SUM:  res_bit = sum_v;
            PICK_LESS: res_bit = less_in;
            default:   res_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_carry_chain.sv
`timescale 1ns/1ps
module alu_carry_chain #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_eff,
    input  logic [W-1:0] b_eff,
    input  logic         cin,
    output logic [W-1:0] carry_vec,
    output logic         cout,
    output logic         ovf_raw,
    output logic         sign_bit
);

    localparam int TOP = W - 1;

    logic [W:0] chain;

    always_comb begin
        chain[0] = cin;
        for (int i = 0; i < W; i++) begin
            chain[i+1] = (a_eff[i] & b_eff[i]) | (chain[i] & (a_eff[i] ^ b_eff[i]));
        end
    end

    assign carry_vec = chain[W-1:0];
    assign cout      = chain[W];
    assign ovf_raw   = chain[W] ^ chain[TOP];
    assign sign_bit  = a_eff[TOP] ^ b_eff[TOP] ^ chain[TOP];

endmodule

// File: rtl/alu_flags.sv
`timescale 1ns/1ps
module alu_flags #(
    parameter int W = 32
) (
    input  logic [W-1:0] raw_res,
    input  logic         legal,
    input  logic         arith,
    input  logic         ovf_raw,
    input  logic         cout_raw,
    output logic [W-1:0] result,
    output logic         zero,
    output logic         overflow,
    output logic         carry_out
);

    assign result    = legal ? raw_res : '0;
    assign zero      = ~|result;
    assign overflow  = arith & ovf_raw;
    assign carry_out = legal & cout_raw;

endmodule

// File: rtl/ripple_alu.sv
`timescale 1ns/1ps
module ripple_alu
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [3:0]   op_code,
    output logic [W-1:0] result,
    output logic         zero,
    output logic         overflow,
    output logic         carry_out
);

    slice_ctl_t   ctl;
    logic [W-1:0] a_eff_vec;
    logic [W-1:0] b_eff_vec;
    logic [W-1:0] carry_vec;
    logic [W-1:0] raw_res;
    logic         cout_raw;
    logic         ovf_raw;
    logic         sign_bit;

    alu_ctl_decode u_decode (
        .op_code (op_code),
        .ctl     (ctl)
    );

    alu_carry_chain #(.W(W)) u_chain (
        .a_eff     (a_eff_vec),
        .b_eff     (b_eff_vec),
        .cin       (ctl.neg_b),
        .carry_vec (carry_vec),
        .cout      (cout_raw),
        .ovf_raw   (ovf_raw),
        .sign_bit  (sign_bit)
    );

    for (genvar i = 0; i < W; i++) begin : g_slice
        logic less_w;
        if (i == 0) begin : g_low
            assign less_w = sign_bit;
        end else begin : g_rest
            assign less_w = 1'b0;
        end
        alu_bit_slice u_slice (
            .a_bit    (opnd_a[i]),
            .b_bit    (opnd_b[i]),
            .neg_a    (ctl.neg_a),
            .neg_b    (ctl.neg_b),
            .pick     (ctl.pick),
            .carry_in (carry_vec[i]),
            .less_in  (less_w),
            .a_eff    (a_eff_vec[i]),
            .b_eff    (b_eff_vec[i]),
            .res_bit  (raw_res[i])
        );
    end

    alu_flags #(.W(W)) u_flags (
        .raw_res   (raw_res),
        .legal     (ctl.legal),
        .arith     (ctl.arith),
        .ovf_raw   (ovf_raw),
        .cout_raw  (cout_raw),
        .result    (result),
        .zero      (zero),
        .overflow  (overflow),
        .carry_out (carry_out)
    );

    always_comb begin
        p_zero_flag_r7: assert (zero == (result == '0))
            else $error("zero flag disagrees with result");
        if (op_code == OP_AND) begin
            p_and_r1: assert (result == (opnd_a & opnd_b))
                else $error("AND result wrong");
        end
        if (op_code == OP_NOR) begin
            p_nor_r6: assert (result == ~(opnd_a | opnd_b))
                else $error("NOR result wrong");
        end
        if (op_code == OP_SLT) begin
            p_slt_upper_r5: assert (result[W-1:1] == '0)
                else $error("SLT upper bits not clear");
        end
        if (op_code != OP_ADD && op_code != OP_SUB) begin
            p_no_overflow_r9: assert (!overflow)
                else $error("overflow outside add/sub");
        end
        if (!(op_code inside {OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR})) begin
            p_unlisted_clear_r10: assert (result == '0 && !carry_out)
                else $error("unlisted code not cleared");
        end
    end

endmodule

// File: tb/ripple_alu_bench.sv
`timescale 1ns/1ps
module ripple_alu_bench;

    localparam int WN = 4;
    localparam int WW = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [WW-1:0] wa, wb, wres;
    logic [3:0]    wop;
    logic          wz, wo, wc;
    logic [WN-1:0] na, nb, nres;
    logic [3:0]    nop;
    logic          nz, no, nc;

    int checks = 0;
    int fails  = 0;

    ripple_alu #(.W(WW)) u_ripple_alu (
        .opnd_a(wa), .opnd_b(wb), .op_code(wop),
        .result(wres), .zero(wz), .overflow(wo), .carry_out(wc)
    );

    ripple_alu #(.W(WN)) u_ripple_alu_narrow (
        .opnd_a(na), .opnd_b(nb), .op_code(nop),
        .result(nres), .zero(nz), .overflow(no), .carry_out(nc)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b0111: return "R5";
            4'b1100: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic model(input int w, input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                         output logic [31:0] r, output logic z, output logic o, output logic c, output bit c_known);
        logic [63:0] mask, sum, diff;
        logic sa, sb, sr;
        mask = (64'd1 << w) - 64'd1;
        sum  = {32'd0, a} + {32'd0, b};
        diff = {32'd0, a} + ((~{32'd0, b}) & mask) + 64'd1;
        sa = a[w-1];
        sb = b[w-1];
        o = 1'b0;
        c = 1'b0;
        c_known = 1'b0;
        case (op)
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b0010: begin
                r = sum[31:0] & mask[31:0];
                sr = r[w-1];
                c = sum[w];
                c_known = 1'b1;
                o = (sa == sb) && (sr != sa);
            end
            4'b0110: begin
                r = diff[31:0] & mask[31:0];
                sr = r[w-1];
                c = diff[w];
                c_known = 1'b1;
                o = (sa != sb) && (sr != sa);
            end
            4'b0111: begin
                r = {31'd0, diff[w-1]};
                c = diff[w];
                c_known = 1'b1;
            end
            4'b1100: r = ~(a | b) & mask[31:0];
            default: begin
                r = 32'd0;
                c_known = 1'b1;
            end
        endcase
        z = (r == 32'd0);
    endtask

    task automatic run(input int w, input logic [31:0] a, input logic [31:0] b, input logic [3:0] op);
        logic [31:0] er, ar;
        logic ez, eo, ec, az, ao, ac;
        bit ck;
        string t;
        @(posedge clk);
        #1;
        if (w == WN) begin
            na = a[WN-1:0]; nb = b[WN-1:0]; nop = op;
        end else begin
            wa = a; wb = b; wop = op;
        end
        @(negedge clk);
        if (w == WN) begin
            ar = {28'd0, nres}; az = nz; ao = no; ac = nc;
        end else begin
            ar = wres; az = wz; ao = wo; ac = wc;
        end
        model(w, a, b, op, er, ez, eo, ec, ck);
        t = op_tag(op);
        chk(ar == er, t, ar, er);
        chk(az == ez, "R7", {31'd0, az}, {31'd0, ez});
        if (op == 4'b0010 || op == 4'b0110)
            chk(ao == eo, "R8", {31'd0, ao}, {31'd0, eo});
        else
            chk(ao == 1'b0, "R9", {31'd0, ao}, 32'd0);
        if (ck) chk(ac == ec, t, {31'd0, ac}, {31'd0, ec});
    endtask

    logic [31:0] corners [6];
    logic [3:0]  legal_ops [6];

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lfsr_a, lfsr_b;
        wa = '0; wb = '0; wop = 4'b0000;
        na = '0; nb = '0; nop = 4'b0000;
        corners[0] = 32'h0000_0000; corners[1] = 32'h8000_0000;
        corners[2] = 32'h7FFF_FFFF; corners[3] = 32'hFFFF_FFFF;
        corners[4] = 32'h0000_0001; corners[5] = 32'h8000_0001;
        legal_ops[0] = 4'b0000; legal_ops[1] = 4'b0001; legal_ops[2] = 4'b0010;
        legal_ops[3] = 4'b0110; legal_ops[4] = 4'b0111; legal_ops[5] = 4'b1100;

        // Idle state with all-zero inputs: AND of zeros, zero flag high (R1, R7)
        @(negedge clk);
        chk(wres == '0, "R1", wres, 32'd0);
        chk(wz == 1'b1, "R7", {31'd0, wz}, 32'd1);

        // Exhaustive narrow sweep: all codes, all operand pairs (R1..R10)
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run(WN, 32'(a), 32'(b), 4'(op));

        // Wide corners: extremes in every pairing, every legal code plus one unlisted code (R10)
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++) begin
                for (int k = 0; k < 6; k++)
                    run(WW, corners[i], corners[j], legal_ops[k]);
                run(WW, corners[i], corners[j], 4'b1011);
            end

        // Equal operands: SUB gives zero flag and carry (R4, R7), SLT gives 0 (R5)
        run(WW, 32'h1234_5678, 32'h1234_5678, 4'b0110);
        run(WW, 32'h1234_5678, 32'h1234_5678, 4'b0111);

        // Pseudo-random walk
        lfsr_a = 32'hACE1_2345;
        lfsr_b = 32'h1357_9BDF;
        for (int n = 0; n < 300; n++) begin
            lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
            lfsr_b = {lfsr_b[30:0], lfsr_b[31] ^ lfsr_b[21] ^ lfsr_b[1] ^ lfsr_b[0]};
            run(WW, lfsr_a, lfsr_b, (n % 3 == 0) ? 4'(n % 16) : legal_ops[n % 6]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule